// File: doc/BRIEF.md
# Auto-Reload Wakeup Timer

This block raises a periodic wakeup event inside a real-time-clock power domain. A down-counter is loaded from a 16-bit reload value and steps once per tick. The tick comes from one of four binary divisions of the RTC clock, or from an external once-per-second strobe. On each expiry the counter reloads at once, a sticky wakeup flag is set, and a single-cycle wakeup pulse is emitted. The interrupt is the flag gated by an interrupt enable.

Software reprograms the reload value and the tick selection only while the timer is stopped. A write-allowed status rises a fixed number of RTC clock cycles after the enable drops. While it is high, the block copies the reload and select inputs into internal shadow registers. At all other times it ignores them. Setting the enable starts a full countdown from the shadow values. A select code with both upper bits set also adds 2^16 to the count, which stretches the period past 18 hours at a 1 Hz tick.

Top module: `wkt_top`

## Requirements
- R1: Select codes 000, 001, 010 and 011 tick every 16, 8, 4 and 2 RTC clock cycles. The prescaler starts from zero when the enable rises, so the first wakeup pulse follows (reload+1)*divisor clock edges.
- R2: Select codes 100 and 101 use the 1 Hz strobe as the tick. The first wakeup follows reload+1 strobes.
- R3: Select codes 110 and 111 use the 1 Hz strobe and add 65536 to the count. Each period is therefore reload+65537 strobes.
- R4: When a tick finds the counter at zero, the counter reloads. Every later period is the same length as the first.
- R5: The interrupt output is high exactly when the wakeup flag is high and the interrupt enable is 1.
- R6: The wakeup flag stays set until a clear strobe is seen at a clock edge. If a new expiry and a clear fall on the same edge, the flag stays set.
- R7: The write-allowed status goes high after the second clock edge with the enable low. It is low in any cycle in which the enable is high.
- R8: The reload and select inputs are captured only at edges where write-allowed is high. Changing them at any other time has no effect on the period.
- R9: Dropping the enable for one cycle and raising it again restarts a full period, with both the counter and the prescaler starting afresh.
- R10: The wakeup pulse is high for the cycle following each expiry edge, and the flag rises together with it.
- R11: While reset is asserted the flag, interrupt, pulse and write-allowed outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle once-per-second strobe |
| enable | input | 1 | Timer run enable |
| irq_en | input | 1 | Interrupt enable |
| reload | input | 16 | Reload value |
| clk_sel | input | 3 | Tick source select code |
| flag_clr | input | 1 | Wakeup flag clear strobe |
| wake_flag | output | 1 | Sticky wakeup flag |
| irq | output | 1 | Wakeup interrupt |
| wr_ok | output | 1 | Reload and select may be written |
| wake_pulse | output | 1 | One-cycle pulse per expiry |

## Verification
The embedded assertions check several properties on every cycle:
- The counter holds between ticks and reloads after an expiry.
- The prescaler clears while stopped.
- The shadow registers stay frozen whenever write-allowed is low.
- The flag is never lost without a clear and rises only together with a wakeup pulse.

Only the bench scenarios can show that each period has the right length for every select code. They also show the extended 2^16 range, the restart after a brief disable, the latency of write-allowed, and that the flag survives a clear that lands on an expiry edge.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int SEL_W = 3;

  // Upper select bit picks the once-per-second strobe
  function automatic logic sel_uses_sec(input logic [SEL_W-1:0] s);
    return s[2];
  endfunction

  // Both upper bits set extend the count by one full reload range
  function automatic logic sel_extends(input logic [SEL_W-1:0] s);
    return s[2] & s[1];
  endfunction
endpackage

// File: rtl/wkt_prescaler.sv
module wkt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int NTAP = 4;

  logic [PRE_W-1:0] pre;
  logic [NTAP-1:0]  taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (!run) pre <= '0;
    else          pre <= pre + 1'b1;
  end

  // tap g fires once every 2^(PRE_W-g) cycles
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign taps[g] = &pre[PRE_W-1-g:0];
  end

  assign tick = run && taps[div_sel];

  p_pre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pre == '0);
endmodule

// File: rtl/wkt_down.sv
module wkt_down #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  input  logic             ext,
  output logic             hit
);
  localparam int TOT_W = CNT_W + 1;

  // start value: reload, plus 2^CNT_W in extended mode
  function automatic logic [TOT_W-1:0] start_val(input logic [CNT_W-1:0] r,
                                                 input logic e);
    return {e, r};
  endfunction

  logic [TOT_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);
  assign hit     = run && tick && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= start_val(reload, ext);
    else if (tick)   cnt <= at_zero ? start_val(reload, ext) : cnt - 1'b1;
  end

  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(cnt));
  p_reload_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt == start_val($past(reload), $past(ext)));
endmodule

// File: rtl/wkt_wrgate.sv
module wkt_wrgate #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic wr_ok
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] idle_cnt;
  logic          settled;

  assign settled = (idle_cnt == CW'(LAT));
  assign wr_ok   = settled && !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_cnt <= '0;
    else if (enable)  idle_cnt <= '0;
    else if (!settled) idle_cnt <= idle_cnt + 1'b1;
  end

  p_wrok_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> !$past(enable));
endmodule

// File: rtl/wkt_top.sv
module wkt_top #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4,
  parameter int WR_LAT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_1hz,
  input  logic                      enable,
  input  logic                      irq_en,
  input  logic [CNT_W-1:0]          reload,
  input  logic [wkt_pkg::SEL_W-1:0] clk_sel,
  input  logic                      flag_clr,
  output logic                      wake_flag,
  output logic                      irq,
  output logic                      wr_ok,
  output logic                      wake_pulse
);
  import wkt_pkg::*;

  logic [CNT_W-1:0] reload_q;
  logic [SEL_W-1:0] sel_q;
  logic             div_tick;
  logic             cnt_tick;
  logic             expiry;

  wkt_wrgate #(.LAT(WR_LAT)) i_gate (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_ok(wr_ok)
  );

  // shadow copies, writable only while the gate is open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      sel_q    <= '0;
    end else if (wr_ok) begin
      reload_q <= reload;
      sel_q    <= clk_sel;
    end
  end

  wkt_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .run(enable), .div_sel(sel_q[1:0]), .tick(div_tick)
  );

  assign cnt_tick = sel_uses_sec(sel_q) ? tick_1hz : div_tick;

  wkt_down #(.CNT_W(CNT_W)) i_down (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(cnt_tick),
    .reload(reload_q), .ext(sel_extends(sel_q)), .hit(expiry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag  <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= expiry;
      if (expiry)        wake_flag <= 1'b1;
      else if (flag_clr) wake_flag <= 1'b0;
    end
  end

  assign irq = wake_flag && irq_en;

  p_flag_with_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> wake_pulse);
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_flag && !flag_clr |=> wake_flag);
  p_pulse_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(enable));
  p_shadow_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(reload_q) && $stable(sel_q));
endmodule

// File: tb/test_wkt_top.sv
module test_wkt_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        enable = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] reload = '0;
  logic [2:0]  clk_sel = '0;
  logic        flag_clr = 1'b0;
  logic        wake_flag, irq, wr_ok, wake_pulse;

  int checks = 0;
  int fails = 0;
  int edge_ct = 0;
  int cur_s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wkt_top i_wkt_top (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .enable(enable),
    .irq_en(irq_en), .reload(reload), .clk_sel(clk_sel), .flag_clr(flag_clr),
    .wake_flag(wake_flag), .irq(irq), .wr_ok(wr_ok), .wake_pulse(wake_pulse)
  );

  function automatic int exp_period(input logic [2:0] sel, input int rl, input int s);
    if (sel[2]) return (rl + 1 + (sel[1] ? 65536 : 0)) * s;
    return (rl + 1) * (16 >> sel[1:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step();
    tick_1hz = (cur_s > 0) && (((edge_ct + 1) % cur_s) == 0);
    @(posedge clk);
    @(negedge clk);
    edge_ct++;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!wake_pulse);
  endtask

  task automatic program_t(input logic [2:0] sel, input int rl, input int s);
    enable = 1'b0;
    reload = 16'(rl);
    clk_sel = sel;
    cur_s = 0;
    repeat (4) step();
    cur_s = sel[2] ? s : 0;
  endtask

  task automatic start();
    enable = 1'b1;
    edge_ct = 0;
  endtask

  initial begin
    int n, n2;
    logic [2:0] sel;
    int rl, s;
    void'($urandom(32'd2024));
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(!wake_flag && !irq && !wake_pulse && !wr_ok, "R11",
        {wake_flag, irq, wake_pulse, wr_ok}, 0);
    rst_n = 1'b1;

    // R7 write-allowed latency
    step();
    chk(wr_ok == 1'b0, "R7 after one idle edge", wr_ok, 0);
    step();
    chk(wr_ok == 1'b1, "R7 after two idle edges", wr_ok, 1);
    enable = 1'b1;
    #1;
    chk(wr_ok == 1'b0, "R7 low while enabled", wr_ok, 0);
    enable = 1'b0;

    // R1 each divisor, R4 second interval
    for (int c = 0; c < 4; c++) begin
      program_t(3'(c), 2, 0);
      start();
      wait_pulse(n);
      chk(n == exp_period(3'(c), 2, 0), "R1 divided period", n, exp_period(3'(c), 2, 0));
      wait_pulse(n2);
      chk(n2 == exp_period(3'(c), 2, 0), "R4 repeat period", n2, exp_period(3'(c), 2, 0));
    end

    // R2 1 Hz mode, both codes
    program_t(3'b100, 4, 3);
    start();
    wait_pulse(n);
    chk(n == 15, "R2 code 100", n, 15);
    program_t(3'b101, 0, 1);
    start();
    wait_pulse(n);
    chk(n == 1, "R2 code 101 reload 0", n, 1);

    // random mix
    for (int k = 0; k < 8; k++) begin
      sel = 3'($urandom_range(5));
      rl = $urandom_range(20);
      s = $urandom_range(3, 1);
      program_t(sel, rl, s);
      start();
      wait_pulse(n);
      chk(n == exp_period(sel, rl, s), sel[2] ? "R2 random" : "R1 random",
          n, exp_period(sel, rl, s));
      wait_pulse(n2);
      chk(n2 == exp_period(sel, rl, s), "R4 random repeat", n2, exp_period(sel, rl, s));
    end

    // R8 input changes while running are ignored
    program_t(3'b001, 3, 0);
    start();
    step(); step();
    reload = 16'd50;
    clk_sel = 3'b011;
    chk(wr_ok == 1'b0, "R8 gate closed while running", wr_ok, 0);
    wait_pulse(n);
    chk(n + 2 == 32, "R8 period unchanged", n + 2, 32);

    // R9 restart after a brief disable
    program_t(3'b000, 1, 0);
    start();
    repeat (10) step();
    enable = 1'b0;
    step();
    start();
    wait_pulse(n);
    chk(n == 32, "R9 restart full period", n, 32);

    // R5, R6, R10 flag behaviour, /2 with reload 0
    program_t(3'b011, 0, 0);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    irq_en = 1'b0;
    start();
    wait_pulse(n);
    chk(n == 2, "R1 /2 reload 0", n, 2);
    chk(wake_flag == 1'b1, "R10 flag with pulse", wake_flag, 1);
    chk(irq == 1'b0, "R5 irq masked", irq, 0);
    irq_en = 1'b1;
    #1;
    chk(irq == 1'b1, "R5 irq enabled", irq, 1);
    step();
    chk(wake_pulse == 1'b0, "R10 pulse one cycle", wake_pulse, 0);
    chk(wake_flag == 1'b1, "R6 flag sticky", wake_flag, 1);
    flag_clr = 1'b1;
    step();
    chk(wake_flag == 1'b1 && wake_pulse == 1'b1, "R6 set wins over clear", wake_flag, 1);
    step();
    chk(wake_flag == 1'b0, "R6 clear", wake_flag, 0);
    chk(irq == 1'b0, "R5 irq follows flag", irq, 0);
    flag_clr = 1'b0;

    // R3 extended range
    program_t(3'b110, 2, 1);
    start();
    wait_pulse(n);
    chk(n == exp_period(3'b110, 2, 1), "R3 extended period", n, exp_period(3'b110, 2, 1));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule